// File: doc/BRIEF.md
# Run-Fill Scanline Pixel Decoder

This block sits in the video path between the framebuffer fetch and the palette lookup. It accepts 16-bit framebuffer words on a valid/ready stream and emits one palette index for each pixel clock on a second valid/ready stream. The block has two modes, selected for each word.

In colour-hold mode, each word is split into packed pixel codes of 4 or 8 bits. A non-zero code is output unchanged and becomes the line's held colour. A zero code repeats the held colour. Software can therefore store filled shapes as their outlines only. In run-length mode, a word carries one colour and a repeat count, and the block expands it into a run of pixels.

A line-start strobe clears the held colour and the pixel position. A programmed line length cuts off any pixels that would fall past the end of the line. A programmable key index, normally a reserved non-zero palette entry used for pass-through, raises a flag on every pixel that carries it. Reserving that entry leaves 14 drawable colours in 4-bit mode and 254 in 8-bit mode.

Top module: `runfill_decoder`

## Requirements
- R1: After reset, and in the cycle after a `lineStart` pulse, `pixValid` is 0 and `inReady` is 1.
- R2: Colour-hold mode with `bpp8`=0 unpacks each word into four 4-bit codes in this order: bits 15:12, then 11:8, then 7:4, then 3:0. Each code is zero-extended to the 8-bit index.
- R3: Colour-hold mode with `bpp8`=1 unpacks each word into two 8-bit codes: bits 15:8 first, then bits 7:0.
- R4: In colour-hold mode, a non-zero code is emitted unchanged and becomes the held colour. A zero code emits the held colour. The held colour carries across words within a line.
- R5: `lineStart` clears the held colour to 0, so zero codes that come before the first non-zero code on a line emit index 0.
- R6: In run-length mode (`modeRun`=1), bits 15:8 of a word are the colour and bits 7:0 are a count N. The colour is emitted N+1 times; a count of 0 gives one pixel.
- R7: At most `lineLen` pixels are emitted between two `lineStart` pulses. The pixels of a word or run that fall past the end are discarded, and `inReady` stays 0 until the next `lineStart`.
- R8: While `pixValid`=1 and `pixReady`=0, `pixValid` stays 1 and `pixOut` holds its value. `inReady` is 0 while a word is still being emitted, so no input word is lost.
- R9: `pixKey` is 1 exactly when `pixValid`=1 and `pixOut` equals `keyIndex`.
- R10: `modeRun` and `bpp8` are captured when a word is accepted. Changing them while that word is still being emitted has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Start-of-line strobe; clears held colour and pixel position |
| lineLen | input | LEN_W | Pixels per line (at least 1) |
| modeRun | input | 1 | 1 = run-length word, 0 = colour-hold packed codes |
| bpp8 | input | 1 | Colour-hold code size: 1 = 8 bits, 0 = 4 bits |
| keyIndex | input | 8 | Reserved pass-through palette index |
| inValid | input | 1 | Framebuffer word valid |
| inData | input | 16 | Framebuffer word |
| inReady | output | 1 | Block can accept a word |
| pixReady | input | 1 | Downstream takes a pixel |
| pixValid | output | 1 | Pixel index valid |
| pixOut | output | 8 | Palette index |
| pixKey | output | 1 | Emitted index equals `keyIndex` |

## Verification
If the held colour were corrupted, it would show up on the very next zero code. That pixel would carry a wrong index, which is visible on `pixOut` in the same cycle it is emitted. A wrong count of remaining slots or run pixels would show up at the word boundary as an extra or a missing pixel, which breaks the order of every later pixel on that line. A wrong pixel-position counter would show only at the end of the line: pixels either spill past `lineLen` or stop before it, and `inReady` would be wrong there.

// File: rtl/runfill_pkg.sv
package runfill_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 8;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // word accepted this cycle
    logic fire;   // pixel taken this cycle
    logic clear;  // line restart
  } rfStrobe_t;
endpackage

// File: rtl/runfill_ctrl.sv
module runfill_ctrl
  import runfill_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [LEN_W-1:0] lineLen,
  input  logic             modeRun,
  input  logic             bpp8,
  input  logic [IDX_W-1:0] runCount,
  input  logic             inValid,
  input  logic             pixReady,
  output logic             inReady,
  output logic             pixValid,
  output rfStrobe_t        stb,
  output logic [1:0]       slot
);
  logic             busy;
  logic             lineDone;
  logic [IDX_W-1:0] remaining;
  logic [LEN_W-1:0] pixCount;
  logic             lastPix;
  logic             lineEnd;

  assign inReady   = !busy && !lineDone;
  assign pixValid  = busy;
  assign stb.clear = lineStart;
  assign stb.load  = inValid && inReady && !lineStart;
  assign stb.fire  = busy && pixReady && !lineStart;
  assign slot      = remaining[1:0];
  assign lastPix   = (remaining == '0);
  assign lineEnd   = (pixCount == lineLen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      lineDone  <= 1'b0;
      remaining <= '0;
      pixCount  <= '0;
    end else if (stb.clear) begin
      busy      <= 1'b0;
      lineDone  <= 1'b0;
      remaining <= '0;
      pixCount  <= '0;
    end else if (stb.load) begin
      busy      <= 1'b1;
      remaining <= modeRun ? runCount : (bpp8 ? IDX_W'(1) : IDX_W'(3));
    end else if (stb.fire) begin
      pixCount  <= pixCount + LEN_W'(1);
      remaining <= remaining - IDX_W'(1);
      if (lineEnd) begin
        busy     <= 1'b0;
        lineDone <= 1'b1;
      end else if (lastPix) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/runfill_dpath.sv
module runfill_dpath
  import runfill_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         stb,
  input  logic [1:0]        slot,
  input  logic [WORD_W-1:0] inData,
  input  logic              modeRun,
  input  logic              bpp8,
  output logic [IDX_W-1:0]  pixOut
);
  logic [WORD_W-1:0] wordQ;
  logic              runQ;
  logic              wideQ;
  logic [IDX_W-1:0]  heldQ;
  logic [IDX_W-1:0]  code;
  logic [IDX_W-1:0]  holdColour;

  // select the packed code for the current slot; the slot counts down
  always_comb begin
    if (wideQ) begin
      code = slot[0] ? wordQ[15:8] : wordQ[7:0];
    end else begin
      case (slot)
        2'd3:    code = {4'h0, wordQ[15:12]};
        2'd2:    code = {4'h0, wordQ[11:8]};
        2'd1:    code = {4'h0, wordQ[7:4]};
        default: code = {4'h0, wordQ[3:0]};
      endcase
    end
    holdColour = (code != '0) ? code : heldQ;
    pixOut     = runQ ? wordQ[15:8] : holdColour;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      runQ  <= 1'b0;
      wideQ <= 1'b0;
      heldQ <= '0;
    end else if (stb.clear) begin
      heldQ <= '0;
    end else begin
      if (stb.load) begin
        wordQ <= inData;
        runQ  <= modeRun;
        wideQ <= bpp8;
      end
      if (stb.fire && !runQ && code != '0) begin
        heldQ <= code;
      end
    end
  end
endmodule

// File: rtl/runfill_decoder.sv
module runfill_decoder
  import runfill_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [LEN_W-1:0]  lineLen,
  input  logic              modeRun,
  input  logic              bpp8,
  input  logic [IDX_W-1:0]  keyIndex,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  input  logic              pixReady,
  output logic              pixValid,
  output logic [IDX_W-1:0]  pixOut,
  output logic              pixKey
);
  rfStrobe_t  stb;
  logic [1:0] slot;

  runfill_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineStart(lineStart),
    .lineLen  (lineLen),
    .modeRun  (modeRun),
    .bpp8     (bpp8),
    .runCount (inData[IDX_W-1:0]),
    .inValid  (inValid),
    .pixReady (pixReady),
    .inReady  (inReady),
    .pixValid (pixValid),
    .stb      (stb),
    .slot     (slot)
  );

  runfill_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .slot   (slot),
    .inData (inData),
    .modeRun(modeRun),
    .bpp8   (bpp8),
    .pixOut (pixOut)
  );

  assign pixKey = pixValid && (pixOut == keyIndex);
endmodule

// File: rtl/runfill_chk.sv
module runfill_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             lineStart,
  input logic [LEN_W-1:0] lineLen,
  input logic             inReady,
  input logic             pixReady,
  input logic             pixValid,
  input logic [7:0]       pixOut,
  input logic             pixKey
);
  logic [LEN_W:0] fired;

  always_ff @(posedge clk) begin
    if (!rstN || lineStart) fired <= '0;
    else if (pixValid && pixReady) fired <= fired + 1'b1;
  end

  a_r1_clear_state: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (inReady && !pixValid));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady && !lineStart) |=> (pixValid && $stable(pixOut)));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && pixValid));

  a_r7_line_cap: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixReady && !lineStart) |-> (fired < {1'b0, lineLen}));

  a_r9_key_qualified: assert property (@(posedge clk) disable iff (!rstN)
    pixKey |-> pixValid);
endmodule

bind runfill_decoder runfill_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lineStart(lineStart),
  .lineLen  (lineLen),
  .inReady  (inReady),
  .pixReady (pixReady),
  .pixValid (pixValid),
  .pixOut   (pixOut),
  .pixKey   (pixKey)
);

// File: tb/test_runfill_decoder.sv
module test_runfill_decoder;
  localparam int LEN_W = 12;

  typedef struct {
    logic [7:0] pix;
    logic       key;
    string      tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             lineStart = 1'b0;
  logic [LEN_W-1:0] lineLen = LEN_W'(320);
  logic             modeRun = 1'b0;
  logic             bpp8 = 1'b0;
  logic [7:0]       keyIndex = 8'h0F;
  logic             inValid = 1'b0;
  logic [15:0]      inData = '0;
  logic             inReady;
  logic             pixReady = 1'b0;
  logic             pixValid;
  logic [7:0]       pixOut;
  logic             pixKey;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit stallMode = 1'b1;

  expItem_t q[$];
  logic [7:0] heldM = '0;
  int cntM = 0;
  int lenM = 320;

  always #2 clk = ~clk;

  runfill_decoder #(.LEN_W(LEN_W)) i_runfill_decoder (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineLen(lineLen),
    .modeRun(modeRun), .bpp8(bpp8), .keyIndex(keyIndex),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .pixReady(pixReady), .pixValid(pixValid), .pixOut(pixOut), .pixKey(pixKey)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic pushPix(input logic [7:0] p, input string tag);
    expItem_t it;
    if (cntM >= lenM) return;
    it.pix = p;
    it.key = (p == keyIndex);
    it.tag = tag;
    q.push_back(it);
    cntM++;
  endtask

  // driver: model the expected pixels, then hand the word over
  task automatic sendWord(input logic [15:0] d, input logic run, input logic b8,
                          input string tag);
    bit ok;
    if (cntM >= lenM) return;
    if (run) begin
      for (int i = 0; i <= int'(d[7:0]); i++) pushPix(d[15:8], tag);
    end else begin
      for (int i = 0; i < (b8 ? 2 : 4); i++) begin
        logic [7:0] c;
        c = b8 ? d[15 - 8*i -: 8] : {4'h0, d[15 - 4*i -: 4]};
        if (c != 8'h00) heldM = c;
        pushPix((c != 8'h00) ? c : heldM, tag);
      end
    end
    @(posedge clk); #1;
    inData = d; modeRun = run; bpp8 = b8; inValid = 1'b1;
    forever begin
      @(negedge clk); ok = inReady;
      @(posedge clk); #1;
      if (ok) break;
    end
    // R10: scramble the mode inputs while the word is still being emitted
    inValid = 1'b0; modeRun = ~run; bpp8 = ~b8; inData = 16'hFFFF;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic newLine(input int len);
    drain();
    lineStart = 1'b1; lineLen = LEN_W'(len);
    @(posedge clk); #1;
    lineStart = 1'b0;
    heldM = '0; cntM = 0; lenM = len;
    @(negedge clk);
    check(inReady === 1'b1 && pixValid === 1'b0, "R1",
          $sformatf("after lineStart inReady=%b pixValid=%b expected 1/0", inReady, pixValid));
  endtask

  // downstream ready pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      pixReady = stallMode ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // monitor: pop and compare, and watch stalls
  initial begin
    bit prevStall = 1'b0;
    logic [7:0] prevPix = '0;
    forever begin
      @(negedge clk);
      if (rstN && !lineStart) begin
        if (prevStall)
          check(pixValid === 1'b1 && pixOut === prevPix, "R8",
                $sformatf("stalled pixel changed: valid=%b pix=%h expected 1/%h",
                          pixValid, pixOut, prevPix));
        if (pixValid && pixReady) begin
          if (q.size() == 0) begin
            check(1'b0, "R7", $sformatf("unexpected pixel %h expected none", pixOut));
          end else begin
            expItem_t e;
            e = q.pop_front();
            check(pixOut === e.pix, e.tag,
                  $sformatf("pixOut=%h expected %h", pixOut, e.pix));
            check(pixKey === e.key, "R9",
                  $sformatf("pixKey=%b expected %b (pix %h)", pixKey, e.key, e.pix));
          end
        end
        prevStall = pixValid && !pixReady;
        prevPix = pixOut;
      end else begin
        prevStall = 1'b0;
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, %0d pixels outstanding", q.size());
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(inReady === 1'b1 && pixValid === 1'b0, "R1",
          $sformatf("after reset inReady=%b pixValid=%b expected 1/0", inReady, pixValid));

    newLine(320);
    // R2 R4 R5: 4-bit unpack order, hold across words, leading zero is 0
    sendWord(16'h0300, 1'b0, 1'b0, "R5");
    sendWord(16'h0005, 1'b0, 1'b0, "R4");
    sendWord(16'hA0B0, 1'b0, 1'b0, "R2");
    // R3: 8-bit unpack order with hold
    sendWord(16'h1200, 1'b0, 1'b1, "R3");
    sendWord(16'h00FF, 1'b0, 1'b1, "R3");
    // R6: run words, count 0 gives one pixel
    sendWord(16'h4502, 1'b1, 1'b0, "R6");
    sendWord(16'h7700, 1'b1, 1'b0, "R6");
    // R4: held colour survives a run word
    sendWord(16'h0000, 1'b0, 1'b1, "R4");

    // R5: held colour cleared by line start
    newLine(320);
    sendWord(16'h0000, 1'b0, 1'b1, "R5");
    // R9: key index flagged
    sendWord(16'hF0E0, 1'b0, 1'b0, "R9");
    sendWord(16'h0FFF, 1'b1, 1'b0, "R10");

    // R7: run cut at line end, then input blocked
    newLine(10);
    sendWord(16'h2214, 1'b1, 1'b0, "R7");
    drain();
    @(negedge clk);
    check(inReady === 1'b0 && pixValid === 1'b0, "R7",
          $sformatf("after line end inReady=%b pixValid=%b expected 0/0", inReady, pixValid));

    // R7: packed word cut at line end
    newLine(6);
    sendWord(16'h1234, 1'b0, 1'b0, "R7");
    sendWord(16'h5678, 1'b0, 1'b0, "R7");
    drain();
    @(negedge clk);
    check(inReady === 1'b0, "R7", $sformatf("inReady=%b expected 0", inReady));

    // R10 with full-rate downstream
    stallMode = 1'b0;
    newLine(320);
    sendWord(16'h3000, 1'b0, 1'b1, "R10");
    sendWord(16'h0C01, 1'b1, 1'b1, "R10");
    drain();
    check(q.size() == 0, "R8", $sformatf("outstanding=%0d expected 0", q.size()));

    done = 1'b1;
    finishRun();
  end
endmodule